// File: doc/BRIEF.md
# I2C DMA Request and Interrupt Controller

This block sits beside an I2C bus engine. It turns byte-level bus events into two DMA request lines, one for receive and one for transmit, and a small bank of sticky interrupt flags. It works for either bus role. In the target role, an address match holds off all data requests until software has acknowledged it. In the controller role, software can bound a transfer with a programmable byte count. When that count runs out, the block stops issuing requests and pulses a stop request back to the engine.

Each DMA request is raised by a bus event and is withdrawn only as a side effect of a data-register access. A read withdraws the receive request and a write withdraws the transmit request. No DMA request is raised unless the smart-mode enable is set. Each interrupt flag is cleared by writing a one to its bit. A single interrupt output combines the flags with a per-flag enable mask.

Top module: `i2c_dma_irq_ctl`

## Requirements
- R1: While `smart_en` is low, both DMA request outputs are low from the next clock edge, and no bus event can raise them.
- R2: In target mode (`ctrl_mode`=0), `ev_addr_hit` sets flag bit 0. While flag bit 0 is set, receive and transmit events raise no DMA request.
- R3: A received-byte event (`ev_rx_byte`) raises `dma_rx_req` one cycle later when requests are allowed. A data-register read (`reg_rd`) lowers it. If both happen in the same cycle, the request stays set.
- R4: A transmit-needed event (`ev_tx_need`) raises `dma_tx_req` when requests are allowed. A data-register write (`reg_wr`) lowers it, and a read does not.
- R5: Flag bit 1 is set by `ev_stop` in target mode only. Flag bit 2 is set by `ev_bus_err` in either mode. Flag bit 3 is set by `ev_own_bus` and flag bit 4 by `ev_peer_bus`, both in controller mode only. `ev_addr_hit` and `ev_stop` have no effect in controller mode. None of these events raises a DMA request.
- R6: In controller mode, an `addr_wr` with `len_en`=1 loads `len_val` into the byte counter, shown on `len_left`. Each data-register access while the count is nonzero decrements it. The access that takes the count from 1 to 0 produces a one-cycle `stop_req` on the next cycle, and so does loading a length of 0. While the bounded count is 0, no DMA request is raised. An `addr_wr` with `len_en`=0 removes the bound.
- R7: Flags are sticky and are cleared by writing 1 to the matching bit of `flag_clr`. A set event and a clear of the same bit in the same cycle leave the flag set.
- R8: `irq` is high whenever `(flags & irq_en)` is nonzero. It follows `irq_en` within the same cycle.
- R9: Synchronous `rst` clears all flags, both requests, the byte counter and `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smart_en | input | 1 | Smart-mode enable; gates all DMA requests |
| ctrl_mode | input | 1 | 1 = controller role, 0 = target role |
| ev_addr_hit | input | 1 | Own address matched (target) |
| ev_rx_byte | input | 1 | Data byte received |
| ev_tx_need | input | 1 | Data byte needed for transmit |
| ev_stop | input | 1 | Stop condition seen |
| ev_bus_err | input | 1 | Bus error |
| ev_own_bus | input | 1 | Controller has the bus and finished a write phase step |
| ev_peer_bus | input | 1 | Controller has the bus with a byte from the peer |
| reg_rd | input | 1 | Data register read strobe |
| reg_wr | input | 1 | Data register write strobe |
| addr_wr | input | 1 | Address register write strobe |
| len_en | input | 1 | Length bound enable, written with the address |
| len_val | input | LEN_W | Transfer length, written with the address |
| flag_clr | input | 5 | Write-one-to-clear mask for flags |
| irq_en | input | 5 | Interrupt enable mask |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| flags | output | 5 | Sticky flags {peer, own, err, stop, addr} |
| irq | output | 1 | Combined interrupt |
| stop_req | output | 1 | One-cycle end-of-transfer pulse to the engine |
| len_left | output | LEN_W | Remaining byte count |

## Verification
Two pairs of actions can land in the same cycle. A new received byte can arrive in the cycle the data register is read. A flag's set event can coincide with software's write-one clear of that same bit. The bench drives each pair in one cycle and checks at the following falling edge that the request or flag is still high. It also checks that a read alone lowers the request, and that a clear alone lowers the flag.

// File: rtl/i2c_dma_irq_ctl.sv
module i2c_dma_irq_ctl #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smart_en,
  input  logic             ctrl_mode,
  input  logic             ev_addr_hit,
  input  logic             ev_rx_byte,
  input  logic             ev_tx_need,
  input  logic             ev_stop,
  input  logic             ev_bus_err,
  input  logic             ev_own_bus,
  input  logic             ev_peer_bus,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic             addr_wr,
  input  logic             len_en,
  input  logic [LEN_W-1:0] len_val,
  input  logic [4:0]       flag_clr,
  input  logic [4:0]       irq_en,
  output logic             dma_rx_req,
  output logic             dma_tx_req,
  output logic [4:0]       flags,
  output logic             irq,
  output logic             stop_req,
  output logic [LEN_W-1:0] len_left
);
  localparam int F_ADDR = 0;
  localparam int F_STOP = 1;
  localparam int F_ERR  = 2;
  localparam int F_OWN  = 3;
  localparam int F_PEER = 4;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic       bounded;
  logic       len_empty;
  logic       req_ok;
  logic       count_dec;
  logic       load_len;
  logic [4:0] flag_set;

  assign len_empty = bounded && (len_left == '0);
  assign req_ok    = smart_en &&
                     (ctrl_mode ? !len_empty : !flags[F_ADDR]);
  assign load_len  = ctrl_mode && addr_wr;
  assign count_dec = ctrl_mode && bounded && !len_empty && (reg_rd || reg_wr) && !load_len;

  assign flag_set[F_ADDR] = ev_addr_hit && !ctrl_mode;
  assign flag_set[F_STOP] = ev_stop && !ctrl_mode;
  assign flag_set[F_ERR]  = ev_bus_err;
  assign flag_set[F_OWN]  = ev_own_bus && ctrl_mode;
  assign flag_set[F_PEER] = ev_peer_bus && ctrl_mode;

  assign irq = |(flags & irq_en);

  always_ff @(posedge clk) begin
    if (rst || !smart_en) begin
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      dma_rx_req <= (ev_rx_byte && req_ok) || (dma_rx_req && !reg_rd);
      dma_tx_req <= (ev_tx_need && req_ok) || (dma_tx_req && !reg_wr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bounded  <= 1'b0;
      len_left <= '0;
      stop_req <= 1'b0;
    end else if (load_len) begin
      bounded  <= len_en;
      len_left <= len_en ? len_val : '0;
      stop_req <= len_en && (len_val == '0);
    end else begin
      stop_req <= count_dec && (len_left == ONE);
      if (count_dec) len_left <= len_left - ONE;
    end
  end

  AST_SMART_GATE: assert property (@(posedge clk) disable iff (rst)
    !smart_en |=> (!dma_rx_req && !dma_tx_req)); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (smart_en && !ctrl_mode && flags[F_ADDR] && !dma_rx_req) |=> !dma_rx_req); // R2
  AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !ev_rx_byte) |=> !dma_rx_req); // R3
  AST_TX_WRITE_CLR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !ev_tx_need) |=> !dma_tx_req); // R4
  AST_LEN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (ctrl_mode && len_empty && !addr_wr && !dma_tx_req) |=> !dma_tx_req); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|(flags & ~flag_clr)) |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr))); // R7
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (rst)
    (stop_req && !addr_wr) |=> !stop_req); // R6
endmodule

// File: tb/i2c_dma_irq_ctl_tb.sv
module i2c_dma_irq_ctl_tb;
  localparam int CLK_P = 10;
  localparam int LEN_W = 8;
  localparam int NV = 22;

  // {smart ctrl addr rx tx stop err own peer rd wr clr[4:0]} {rxreq txreq flags[4:0] irq}
  localparam logic [23:0] VEC [0:NV-1] = '{
    24'b1_0_1_0_0_0_0_0_0_0_0_00000_0_0_00001_1,
    24'b1_0_0_1_0_0_0_0_0_0_0_00000_0_0_00001_1,
    24'b1_0_0_0_0_0_0_0_0_0_0_00001_0_0_00000_0,
    24'b1_0_0_1_0_0_0_0_0_0_0_00000_1_0_00000_0,
    24'b1_0_0_0_0_0_0_0_0_1_0_00000_0_0_00000_0,
    24'b1_0_0_1_0_0_0_0_0_1_0_00000_1_0_00000_0,
    24'b1_0_0_0_0_0_0_0_0_1_0_00000_0_0_00000_0,
    24'b1_0_0_0_1_0_0_0_0_0_0_00000_0_1_00000_0,
    24'b1_0_0_0_0_0_0_0_0_1_0_00000_0_1_00000_0,
    24'b1_0_0_0_0_0_0_0_0_0_1_00000_0_0_00000_0,
    24'b1_0_0_0_0_1_0_0_0_0_0_00000_0_0_00010_1,
    24'b1_0_0_0_0_0_1_0_0_0_0_00010_0_0_00100_1,
    24'b1_0_1_0_0_0_0_0_0_0_0_00001_0_0_00101_1,
    24'b1_0_0_0_0_0_0_0_0_0_0_11111_0_0_00000_0,
    24'b0_0_0_1_0_0_0_0_0_0_0_00000_0_0_00000_0,
    24'b0_0_0_0_1_0_0_0_0_0_0_00000_0_0_00000_0,
    24'b1_1_1_0_0_1_0_0_0_0_0_00000_0_0_00000_0,
    24'b1_1_0_0_0_0_0_1_0_0_0_00000_0_0_01000_1,
    24'b1_1_0_1_0_0_0_0_1_0_0_00000_1_0_11000_1,
    24'b1_1_0_0_0_0_0_0_0_1_0_11000_0_0_00000_0,
    24'b1_1_0_0_1_0_0_0_0_0_0_00000_0_1_00000_0,
    24'b0_1_0_0_0_0_0_0_0_0_0_00000_0_0_00000_0
  };

  function automatic string tag(input int i);
    case (i)
      0, 1, 2: return "R2";
      3, 4, 5, 6: return "R3";
      7, 8, 9: return "R4";
      10, 11: return "R5";
      12, 13: return "R7";
      14, 15, 21: return "R1";
      default: return "R5";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst, smart_en, ctrl_mode, ev_addr_hit, ev_rx_byte, ev_tx_need, ev_stop;
  logic ev_bus_err, ev_own_bus, ev_peer_bus, reg_rd, reg_wr, addr_wr, len_en;
  logic [LEN_W-1:0] len_val;
  logic [4:0] flag_clr, irq_en;
  logic dma_rx_req, dma_tx_req, irq, stop_req;
  logic [4:0] flags;
  logic [LEN_W-1:0] len_left;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_dma_irq_ctl #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .smart_en(smart_en), .ctrl_mode(ctrl_mode),
    .ev_addr_hit(ev_addr_hit), .ev_rx_byte(ev_rx_byte), .ev_tx_need(ev_tx_need),
    .ev_stop(ev_stop), .ev_bus_err(ev_bus_err), .ev_own_bus(ev_own_bus),
    .ev_peer_bus(ev_peer_bus), .reg_rd(reg_rd), .reg_wr(reg_wr), .addr_wr(addr_wr),
    .len_en(len_en), .len_val(len_val), .flag_clr(flag_clr), .irq_en(irq_en),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req), .flags(flags), .irq(irq),
    .stop_req(stop_req), .len_left(len_left)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_pulses();
    ev_addr_hit = 0; ev_rx_byte = 0; ev_tx_need = 0; ev_stop = 0; ev_bus_err = 0;
    ev_own_bus = 0; ev_peer_bus = 0; reg_rd = 0; reg_wr = 0; addr_wr = 0; flag_clr = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_pulses();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_pulses();
    rst = 1; smart_en = 0; ctrl_mode = 0; len_en = 0; len_val = '0; irq_en = '1;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R9", "reset state", {dma_rx_req, dma_tx_req, flags, stop_req, len_left}, '0);

    for (int i = 0; i < NV; i++) begin
      {smart_en, ctrl_mode, ev_addr_hit, ev_rx_byte, ev_tx_need, ev_stop, ev_bus_err,
       ev_own_bus, ev_peer_bus, reg_rd, reg_wr, flag_clr} = VEC[i][23:8];
      tick();
      check(tag(i), $sformatf("vector %0d", i), {dma_rx_req, dma_tx_req, flags, irq}, VEC[i][7:0]);
    end

    // R8 interrupt mask
    smart_en = 1; ctrl_mode = 0; ev_stop = 1; tick();
    irq_en = 5'b01000; #1;
    check("R8", "masked irq", irq, 0);
    irq_en = 5'b00010; #1;
    check("R8", "enabled irq", irq, 1);
    flag_clr = 5'b11111; tick();
    irq_en = '1;

    // R6 bounded controller transfer of 3 bytes
    ctrl_mode = 1; addr_wr = 1; len_en = 1; len_val = 8'd3; tick();
    check("R6", "length load", len_left, 3);
    for (int b = 0; b < 3; b++) begin
      ev_rx_byte = 1; tick();
      check("R6", "rx request within length", dma_rx_req, 1);
      reg_rd = 1; tick();
      check("R6", "stop pulse timing", stop_req, (b == 2));
    end
    check("R6", "count exhausted", len_left, 0);
    ev_rx_byte = 1; tick();
    check("R6", "no request after length", dma_rx_req, 0);
    check("R6", "stop pulse one cycle", stop_req, 0);
    addr_wr = 1; len_en = 0; tick();
    ev_rx_byte = 1; tick();
    check("R6", "unbounded request", dma_rx_req, 1);
    reg_rd = 1; tick();
    addr_wr = 1; len_en = 1; len_val = 8'd0; tick();
    check("R6", "zero length stop", stop_req, 1);
    ev_tx_need = 1; tick();
    check("R6", "zero length blocks tx", dma_tx_req, 0);

    // R9 reset mid-transfer
    addr_wr = 1; len_val = 8'd5; ev_bus_err = 1; tick();
    ev_tx_need = 1; tick();
    rst = 1; tick(); rst = 0;
    check("R9", "reset clears all", {dma_rx_req, dma_tx_req, flags, stop_req, len_left}, '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule